// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller with Service Register

This block collects edge or level events from a set of GPIO pins arranged in numbered groups of sixteen sources and merges them into one interrupt line. Each source has a four-bit trigger code (shared by four neighbouring sources), a mask bit and a pending bit. Pending bits latch whenever their trigger condition is seen on the synchronised pin. The mask decides only whether a pending bit is visible to the interrupt line and to the service register.

Software reads a single service word to find out which source to handle next. The word holds the group and the pin of the winning source. Software handles that source, clears its pending bit with a write-one-to-clear, and reads the service word again until it reads zero. Configuration and status use a 32-bit word bus with one-cycle registered reads. Each control, mask and pending word packs two groups.

Top module: `gpio_grp_irq`

## Requirements
- R1: After a synchronous reset, all trigger codes are 0, all mask bits are 1, all pending bits are 0, `irq_o` is low and the service word reads 0.
- R2: Each pin passes through two synchronising flops. After a rising pin change that is driven before clock edge 1, the matching pending bit is set at edge 3, and a read sampled at edge 4 is the first read to return it.
- R3: A trigger code selects the event. With bits [2:1] = 0 the source is level-sensitive: bit 0 = 0 means active low, bit 0 = 1 means active high. Otherwise bit 1 enables falling edges and bit 2 enables rising edges. Code 2 is falling, 4 is rising, 6 is both. Bit 3 has no effect.
- R4: Source a = 16·(g−1) + p, where g is the group (1..NUM_GROUPS) and p the pin (0..15). Its trigger field is at byte address 0x200 + 4·(a/32), bits 4·((a mod 32)/4) +: 4. The four sources of one field share it.
- R5: Mask bits are at 0x240 + 4·(a/32), bit a mod 32. A mask bit of 1 keeps its source away from `irq_o` and the service word, but the pending bit still latches.
- R6: Pending bits are at 0x260 + 4·(a/32), bit a mod 32. Writing 1 clears a bit and writing 0 leaves it alone. An event in the same cycle as the clear wins, so the bit stays set.
- R7: A level-triggered source sets its pending bit again on every cycle its level stays active, so a clear takes effect only once the level has gone away.
- R8: The service word at 0x284 gives the group in bits [7:4] and the pin in bits [3:0] of the pending, unmasked source with the lowest group, and within that group the lowest pin. It reads 0 when no such source exists. Bits [31:8] read 0.
- R9: The sixteen sources of group 1, which can come from two 8-pin banks, are reported as pins 0–7 and 8–15 of group 1.
- R10: `irq_o` is a register. At each clock edge it takes the value 1 if at least one pending bit with a clear mask bit existed before that edge, and 0 otherwise.
- R11: `bus_rdata` is updated at the edge where `bus_rd` is sampled. Unused bits and unmapped addresses read 0. Writes to the service word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NUM_GROUPS*16 | Asynchronous GPIO inputs, index a = 16·(g−1)+p |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest situation to reach is a service word that must pick among several sources that are pending at the same time, some of them masked and some of them in lower groups. The stimulus builds this up step by step. It latches a masked source first, then a falling event in group 3, then a two-edge event in group 9. It then clears the winners one at a time and reads the service word after each clear. The level-triggered case is driven so that a clear lands while the level is still active, which shows the bit setting itself again. The bench also issues back-to-back reads right after a pin change to find the exact edge at which the synchroniser lets the pending bit appear.

// File: rtl/gpio_grp_irq_pkg.sv
package gpio_grp_irq_pkg;
  localparam int GROUP_PINS = 16;
  localparam int WORD_BITS  = 32;
  localparam int FIELD_SRCS = 4;
  // word indices (byte address / 4) of the register windows
  localparam int CTRL_W = 'h080;
  localparam int MASK_W = 'h090;
  localparam int PEND_W = 'h098;
  localparam int SVC_W  = 'h0A1;

  // event test for one source given its trigger code
  function automatic logic trig_event(input logic [3:0] code, input logic cur,
                                      input logic prev);
    if (code[2:1] == 2'b00) return (cur == code[0]);
    return (code[1] & prev & ~cur) | (code[2] & ~prev & cur);
  endfunction
endpackage

// File: rtl/gpio_grp_irq_sync.sv
module gpio_grp_irq_sync #(
  parameter int N = 144
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] s1_q, s2_q, prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= '1;
      s2_q  <= '1;
      prv_q <= '1;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = prv_q;
endmodule

// File: rtl/gpio_grp_irq_regs.sv
module gpio_grp_irq_regs
  import gpio_grp_irq_pkg::*;
#(
  parameter int NUM_SRC = 144,
  parameter int ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_BITS-1:0]  wdata,
  input  logic [NUM_SRC-1:0]    cur,
  input  logic [NUM_SRC-1:0]    prev,
  output logic [NUM_SRC-1:0]    trig_q,
  output logic [NUM_SRC-1:0]    mask_q,
  output logic [NUM_SRC-1:0]    pend_q
);
  localparam int NF  = NUM_SRC / FIELD_SRCS;
  localparam int FPW = WORD_BITS / FIELD_SRCS;

  logic [ADDR_W-3:0] widx;
  logic [NUM_SRC-1:0] evt, clr;

  assign widx = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
    end else if (wr_en) begin
      for (int f = 0; f < NF; f++)
        if (int'(widx) == CTRL_W + f / FPW)
          trig_q[4*f +: 4] <= wdata[4*(f % FPW) +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en) begin
      for (int a = 0; a < NUM_SRC; a++)
        if (int'(widx) == MASK_W + a / WORD_BITS)
          mask_q[a] <= wdata[a % WORD_BITS];
    end
  end

  for (genvar a = 0; a < NUM_SRC; a++) begin : g_src
    assign evt[a] = trig_event(trig_q[4*(a/4) +: 4], cur[a], prev[a]);
    assign clr[a] = wr_en && (int'(widx) == PEND_W + a / WORD_BITS)
                    && wdata[a % WORD_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | evt;
  end
endmodule

// File: rtl/gpio_grp_irq_svc.sv
module gpio_grp_irq_svc
  import gpio_grp_irq_pkg::*;
#(
  parameter int NUM_SRC = 144
) (
  input  logic [NUM_SRC-1:0] active,
  output logic [7:0]         code
);
  always_comb begin
    code = 8'h00;
    for (int a = NUM_SRC - 1; a >= 0; a--)
      if (active[a]) code = {4'(a / GROUP_PINS + 1), 4'(a % GROUP_PINS)};
  end
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
  import gpio_grp_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 9,
  parameter int ADDR_W     = 12,
  parameter int NUM_SRC    = NUM_GROUPS * GROUP_PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   pin_i,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic                 irq_o
);
  localparam int NW = (NUM_SRC + WORD_BITS - 1) / WORD_BITS;

  logic [NUM_SRC-1:0] cur, prev, trig_q, mask_q, pend_q, active;
  logic [7:0] svc_code;
  logic [WORD_BITS-1:0] rd_word;
  logic [ADDR_W-3:0] widx;
  logic unused_addr_lsb;

  assign widx = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  gpio_grp_irq_sync #(.N(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cur_o(cur), .prev_o(prev));

  gpio_grp_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cur(cur), .prev(prev),
    .trig_q(trig_q), .mask_q(mask_q), .pend_q(pend_q));

  assign active = pend_q & ~mask_q;

  gpio_grp_irq_svc #(.NUM_SRC(NUM_SRC)) u_svc (
    .active(active), .code(svc_code));

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < WORD_BITS; b++) begin
        if (w * WORD_BITS + b < NUM_SRC) begin
          if (int'(widx) == CTRL_W + w)
            rd_word[b] = trig_q[w * WORD_BITS + b];
          if (int'(widx) == MASK_W + w)
            rd_word[b] = mask_q[w * WORD_BITS + b];
          if (int'(widx) == PEND_W + w)
            rd_word[b] = pend_q[w * WORD_BITS + b];
        end
      end
    end
    if (int'(widx) == SVC_W) rd_word = {24'h0, svc_code};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq_o <= |active;
    end
  end
endmodule

// File: rtl/gpio_grp_irq_chk.sv
module gpio_grp_irq_chk #(
  parameter int NUM_SRC    = 144,
  parameter int NUM_GROUPS = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [7:0]         svc,
  input logic               irq
);
  logic hit;
  int   grp, idx;

  always_comb begin
    hit = 1'b0;
    grp = int'(svc[7:4]);
    idx = 0;
    if (grp >= 1 && grp <= NUM_GROUPS) begin
      idx = (grp - 1) * 16 + int'(svc[3:0]);
      hit = pend[idx] & ~mask[idx];
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!irq && pend == '0));

  // R8
  svc_none_chk: assert property (@(posedge clk) disable iff (rst)
    (svc[7:4] == 4'h0) |-> ((pend & ~mask) == '0));

  // R8
  svc_src_chk: assert property (@(posedge clk) disable iff (rst)
    (svc[7:4] != 4'h0) |-> hit);

  // R8
  svc_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(svc[7:4]) <= NUM_GROUPS);

  // R5
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq);

  // R10
  svc_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (svc != 8'h00) |=> irq);
endmodule

bind gpio_grp_irq gpio_grp_irq_chk #(.NUM_SRC(NUM_SRC), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q), .svc(svc_code), .irq(irq_o));

// File: tb/gpio_grp_irq_test.sv
module gpio_grp_irq_test;
  localparam int NG = 9;
  localparam int NS = NG * 16;
  localparam int NF = NS / 4;
  localparam int NW = (NS + 31) / 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] pins = '1;
  logic wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #5 clk = ~clk;

  gpio_grp_irq #(.NUM_GROUPS(NG)) uut (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  int checks = 0, fails = 0;
  string cur_tag = "R11";

  // behavioural reference model
  logic [3:0] m_trig [NF];
  logic [NS-1:0] m_mask, m_pend, m_s1, m_s2, m_pv, m_ev;
  logic m_irq = 1'b0, m_rv = 1'b0;
  logic [31:0] m_rdata = '0;
  string m_rtag = "R11";

  function automatic logic m_evt(logic [3:0] c, logic cu, logic pv);
    if (c[2:1] == 2'b00) return cu == c[0];
    return (c[1] & pv & ~cu) | (c[2] & ~pv & cu);
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h284) begin
      for (int s = NS - 1; s >= 0; s--)
        if (m_pend[s] && !m_mask[s]) r = 32'((s / 16 + 1) * 16 + s % 16);
      return r;
    end
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < NS) begin
          if (a == 12'(12'h200 + 4 * w)) r[b] = m_trig[(w * 32 + b) / 4][b % 4];
          if (a == 12'(12'h240 + 4 * w)) r[b] = m_mask[w * 32 + b];
          if (a == 12'(12'h260 + 4 * w)) r[b] = m_pend[w * 32 + b];
        end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NF; f++) m_trig[f] = 4'h0;
      m_mask = '1; m_pend = '0; m_s1 = '1; m_s2 = '1; m_pv = '1;
      m_irq = 1'b0; m_rv = 1'b0; m_rdata = '0;
    end else begin
      m_rv = rd;
      if (rd) begin m_rdata = m_read(addr); m_rtag = cur_tag; end
      m_irq = |(m_pend & ~m_mask);
      for (int s = 0; s < NS; s++) m_ev[s] = m_evt(m_trig[s / 4], m_s2[s], m_pv[s]);
      for (int s = 0; s < NS; s++)
        if (wr && addr == 12'(12'h260 + 4 * (s / 32)) && wdata[s % 32]) m_pend[s] = 1'b0;
      m_pend = m_pend | m_ev;
      if (wr)
        for (int w = 0; w < NW; w++) begin
          for (int k = 0; k < 8; k++)
            if (addr == 12'(12'h200 + 4 * w) && 8 * w + k < NF)
              m_trig[8 * w + k] = wdata[4 * k +: 4];
          for (int b = 0; b < 32; b++)
            if (addr == 12'(12'h240 + 4 * w) && w * 32 + b < NS)
              m_mask[w * 32 + b] = wdata[b];
        end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model comparison every cycle
  always @(negedge clk) begin
    if (!rst) begin
      check(irq === m_irq, "R10", 32'(irq), 32'(m_irq));
      if (m_rv) check(rdata === m_rdata, m_rtag, rdata, m_rdata);
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd = 1'b1; addr = a; cur_tag = tag;
    @(negedge clk);
    rd = 1'b0;
    check(rdata === exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd_expect(12'h200, 32'h0, "R1");
    rd_expect(12'h240, 32'hFFFF_FFFF, "R1");
    rd_expect(12'h260, 32'h0, "R1");
    rd_expect(12'h284, 32'h0, "R1");
    check(irq === 1'b0, "R1", 32'(irq), 32'h0);
    rd_expect(12'h250, 32'h0000_FFFF, "R11");
    // R4: rising on group 1 pin 0, field 0
    wr_reg(12'h200, 32'h0000_0004);
    wr_reg(12'h240, 32'hFFFF_FFFE);
    pins[0] = 1'b0; idle(5);
    rd_expect(12'h260, 32'h0, "R3");
    pins[0] = 1'b1;
    // R2 latency
    rd_expect(12'h260, 32'h0, "R2");
    rd_expect(12'h260, 32'h0, "R2");
    rd_expect(12'h260, 32'h0, "R2");
    rd_expect(12'h260, 32'h1, "R2");
    check(irq === 1'b1, "R10", 32'(irq), 32'h1);
    rd_expect(12'h284, 32'h10, "R8");
    // R5: masked source in shared field still latches
    pins[2] = 1'b0; idle(5); pins[2] = 1'b1; idle(5);
    rd_expect(12'h260, 32'h5, "R5");
    rd_expect(12'h284, 32'h10, "R5");
    wr_reg(12'h260, 32'h1); idle(1);
    rd_expect(12'h260, 32'h4, "R6");
    rd_expect(12'h284, 32'h0, "R5");
    idle(2);
    check(irq === 1'b0, "R5", 32'(irq), 32'h0);
    wr_reg(12'h260, 32'h0); idle(1);
    rd_expect(12'h260, 32'h4, "R6");
    // falling on group 3 pin 5
    wr_reg(12'h204, 32'h0000_0020);
    wr_reg(12'h244, 32'hFFFF_FFDF);
    pins[37] = 1'b0; idle(5);
    rd_expect(12'h284, 32'h35, "R3");
    // both edges on group 9 pin 15, priority
    wr_reg(12'h210, 32'h0000_6000);
    wr_reg(12'h250, 32'hFFFF_7FFF);
    pins[143] = 1'b0; idle(5);
    rd_expect(12'h284, 32'h35, "R8");
    wr_reg(12'h264, 32'h20); idle(1);
    rd_expect(12'h284, 32'h9F, "R8");
    wr_reg(12'h270, 32'h8000); idle(1);
    rd_expect(12'h284, 32'h0, "R8");
    pins[143] = 1'b1; idle(5);
    rd_expect(12'h284, 32'h9F, "R3");
    wr_reg(12'h270, 32'h8000); idle(1);
    // R7 level high on group 2 pin 9 (source 25)
    wr_reg(12'h200, 32'h0100_0004);
    wr_reg(12'h240, 32'hFDFF_FFFE);
    idle(3);
    rd_expect(12'h284, 32'h29, "R4");
    wr_reg(12'h260, 32'h0200_0000); idle(1);
    rd_expect(12'h260, 32'h0F00_0004, "R7");
    pins[27:24] = 4'h0; idle(4);
    wr_reg(12'h260, 32'h0F00_0000); idle(1);
    rd_expect(12'h260, 32'h4, "R7");
    // R3 bit 3 ignored: code C acts as rising on group 1 pin 12
    wr_reg(12'h200, 32'h0200_C004);
    wr_reg(12'h240, 32'hFFFF_EFFE);
    pins[12] = 1'b0; idle(5);
    rd_expect(12'h260, 32'h4, "R3");
    pins[12] = 1'b1; idle(5);
    rd_expect(12'h284, 32'h1C, "R9");
    rd_expect(12'h260, 32'h1004, "R9");
    // R11 service write ignored, unmapped read
    wr_reg(12'h284, 32'h0); idle(1);
    rd_expect(12'h284, 32'h1C, "R11");
    rd_expect(12'h300, 32'h0, "R11");
    // R3 level low on group 4 pin 0 (source 48)
    pins[48] = 1'b0; idle(5);
    rd_expect(12'h264, 32'h0001_0000, "R3");
    rd_expect(12'h284, 32'h1C, "R8");
    wr_reg(12'h240, 32'hFFFF_FFFF); idle(3);
    check(irq === 1'b0, "R5", 32'(irq), 32'h0);
    idle(2);
    summary();
    $finish;
  end
endmodule